// File: doc/BRIEF.md
# Eight-Target Outbound Mailbox

This block is the sending half of an inter-processor mailbox. Local software stages a 64-bit message as two 32-bit words through a small word-addressed register port. It then names one of eight target cores and writes a trigger. The block keeps a separate message slot for each target. An accepted message sits in its slot, with a per-target valid line raised, until that target pulses its fetch input.

A single status word shows three per-target bitmaps: pending (not yet fetched), delivered and overflowed. Software clears the delivered and overflow flags by writing a bit pattern to a clear register. A sticky interrupt flag is raised by any unmasked event and cleared by software. It drives the interrupt output.

Top module: `mbx_outbound`

## Requirements
- R1: After reset the status word at 0x14 reads 0, the mask register at 0x1C reads 3'b111, the pending flag at 0x18 reads 0, `irq` is 0 and no `tgt_valid` bit is set.
- R2: Writes to 0x4 (low word), 0x8 (high word) and 0x0 (target index, bits 2:0) are held and read back at the same offsets.
- R3: A write to 0xC with bit 0 = 1, aimed at a target whose pending bit (status bit i) is clear, sets that bit and `tgt_valid[i]`. It also copies {high, low} into that target's 64-bit slot of `tgt_data` (bits i*64 upward). A write to 0xC with bit 0 = 0 changes nothing.
- R4: A `tgt_fetch[i]` pulse while target i is pending clears status bit i and `tgt_valid[i]` and sets delivered flag bit 16+i. All of this happens in the same clock cycle.
- R5: A trigger aimed at a pending target sets its overflow flag at status bit 8+i. The new message is dropped, and the slot keeps its earlier contents.
- R6: A `tgt_fetch[i]` pulse while target i is not pending leaves the status word unchanged.
- R7: A write to 0x10 clears delivered flag i where written bit 16+i is 1, and overflow flag i where written bit 8+i is 1. The other flags and all pending bits are unchanged. A flag set in the same cycle as its clear stays set.
- R8: Mask bit 0 gates the accepted-send event, bit 1 gates the overflow event and bit 2 gates the delivery event. A mask bit of 1 disables its event.
- R9: An unmasked event sets the pending interrupt flag (0x18 bit 0) in the cycle it occurs, and `irq` follows that flag. Writing 1 to 0x18 bit 0 clears the flag unless an unmasked event occurs in the same cycle, in which case the flag stays set.
- R10: The eight targets are independent: a send, fetch or overflow on one target changes no flag or slot of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address of the register (word aligned) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tgt_valid | output | 8 | Per-target message-pending flags |
| tgt_data | output | 512 | Per-target 64-bit message slots, target i at bits i*64 upward |
| tgt_fetch | input | 8 | Per-target fetch pulse from the remote side |
| irq | output | 1 | Interrupt request, the pending interrupt flag |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a software clear of the interrupt flag landing in the very cycle a remote fetch raises a new unmasked delivery event. The other is a trigger aimed at a target that is still pending. The bench reaches the first with a task that drives the register write and the fetch pulse between the same pair of falling edges. It reaches the second by triggering a target twice before any fetch, and then checks that the slot still holds the first message.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int N_TGT   = 8;
    localparam int TGT_W   = $clog2(N_TGT);
    localparam int WORD_W  = 32;
    localparam int MSG_W   = 2 * WORD_W;
    localparam int ADDR_W  = 6;
    localparam int MASK_W  = 3;

    localparam logic [ADDR_W-1:0] OFS_TGT  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_LO   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_HI   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_TRIG = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_STS  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_PEND = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_MASK = 6'h1C;

    // status word field positions (decoded by software)
    localparam int BUSY_LSB = 0;
    localparam int OVF_LSB  = 8;
    localparam int DLV_LSB  = 16;

    // mask bit positions
    localparam int MSK_ACC = 0;
    localparam int MSK_OVF = 1;
    localparam int MSK_DLV = 2;

    typedef struct packed {
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
        logic [TGT_W-1:0]  tgt;
        logic [MASK_W-1:0] mask;
    } regs_t;

    typedef struct packed {
        logic             busy;
        logic             dlv;
        logic             ovf;
        logic [MSG_W-1:0] msg;
    } chan_t;
endpackage

// File: rtl/mbx_regs.sv
module mbx_regs
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [N_TGT-1:0]  sts_busy,
    input  logic [N_TGT-1:0]  sts_dlv,
    input  logic [N_TGT-1:0]  sts_ovf,
    input  logic              pend,
    output logic [MSG_W-1:0]  msg,
    output logic [TGT_W-1:0]  tgt,
    output logic [MASK_W-1:0] mask,
    output logic              trig,
    output logic              clr_wr,
    output logic              pend_clr
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            unique case (reg_addr)
                OFS_LO:   r_d.lo   = reg_wdata;
                OFS_HI:   r_d.hi   = reg_wdata;
                OFS_TGT:  r_d.tgt  = reg_wdata[TGT_W-1:0];
                OFS_MASK: r_d.mask = reg_wdata[MASK_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.lo   <= '0;
            r_q.hi   <= '0;
            r_q.tgt  <= '0;
            r_q.mask <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign trig     = reg_wr && (reg_addr == OFS_TRIG) && reg_wdata[0];
    assign clr_wr   = reg_wr && (reg_addr == OFS_CLR);
    assign pend_clr = reg_wr && (reg_addr == OFS_PEND) && reg_wdata[0];
    assign msg      = {r_q.hi, r_q.lo};
    assign tgt      = r_q.tgt;
    assign mask     = r_q.mask;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_TGT:  reg_rdata[TGT_W-1:0]  = r_q.tgt;
            OFS_LO:   reg_rdata             = r_q.lo;
            OFS_HI:   reg_rdata             = r_q.hi;
            OFS_STS: begin
                reg_rdata[BUSY_LSB +: N_TGT] = sts_busy;
                reg_rdata[OVF_LSB  +: N_TGT] = sts_ovf;
                reg_rdata[DLV_LSB  +: N_TGT] = sts_dlv;
            end
            OFS_PEND: reg_rdata[0]          = pend;
            OFS_MASK: reg_rdata[MASK_W-1:0] = r_q.mask;
            default:  ;
        endcase
    end

    // R8: a mask write lands in the next cycle
    p_mask_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_MASK) |=> (mask == $past(reg_wdata[MASK_W-1:0])));
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan
    import mbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send,
    input  logic             fetch,
    input  logic             clr_dlv,
    input  logic             clr_ovf,
    input  logic [MSG_W-1:0] msg_in,
    output logic             busy,
    output logic             dlv,
    output logic             ovf,
    output logic [MSG_W-1:0] msg_out,
    output logic             ev_acc,
    output logic             ev_ovf,
    output logic             ev_dlv
);
    chan_t c_d, c_q;

    assign ev_acc = send && !c_q.busy;
    assign ev_ovf = send && c_q.busy;
    assign ev_dlv = fetch && c_q.busy;

    always_comb begin
        c_d = c_q;
        if (clr_dlv) c_d.dlv = 1'b0;
        if (clr_ovf) c_d.ovf = 1'b0;
        if (ev_dlv) begin
            c_d.busy = 1'b0;
            c_d.dlv  = 1'b1;
        end
        if (ev_ovf) c_d.ovf = 1'b1;
        if (ev_acc) begin
            c_d.busy = 1'b1;
            c_d.msg  = msg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy    = c_q.busy;
    assign dlv     = c_q.dlv;
    assign ovf     = c_q.ovf;
    assign msg_out = c_q.msg;

    p_fetch_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && busy && !send) |=> (!busy && dlv));
    p_drop_on_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (send && busy) |=> (ovf && $stable(msg_out)));
    p_idle_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && !busy && !send && !clr_dlv) |=> (!busy && dlv == $past(dlv)));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MASK_W-1:0] mask,
    input  logic              any_acc,
    input  logic              any_ovf,
    input  logic              any_dlv,
    input  logic              pend_clr,
    output logic              pend
);
    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t i_d, i_q;
    logic evt;

    assign evt = (any_acc && !mask[MSK_ACC]) ||
                 (any_ovf && !mask[MSK_OVF]) ||
                 (any_dlv && !mask[MSK_DLV]);

    always_comb begin
        i_d = i_q;
        if (pend_clr) i_d.pend = 1'b0;
        if (evt)      i_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign pend = i_q.pend;

    p_event_raises_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend);
    p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && !evt) |=> !pend);
endmodule

// File: rtl/mbx_outbound.sv
module mbx_outbound
    import mbx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [WORD_W-1:0]      reg_wdata,
    output logic [WORD_W-1:0]      reg_rdata,
    output logic [N_TGT-1:0]       tgt_valid,
    output logic [N_TGT*MSG_W-1:0] tgt_data,
    input  logic [N_TGT-1:0]       tgt_fetch,
    output logic                   irq
);
    logic [MSG_W-1:0]  msg;
    logic [TGT_W-1:0]  tgt;
    logic [MASK_W-1:0] mask;
    logic              trig, clr_wr, pend_clr, pend;
    logic [N_TGT-1:0]  busy, dlv, ovf, ev_acc, ev_ovf, ev_dlv;

    mbx_regs u_regs (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .sts_busy(busy), .sts_dlv(dlv), .sts_ovf(ovf), .pend,
        .msg, .tgt, .mask, .trig, .clr_wr, .pend_clr
    );

    for (genvar i = 0; i < N_TGT; i++) begin : g_chan
        mbx_chan u_chan (
            .clk, .rst_n,
            .send    (trig && (tgt == TGT_W'(i))),
            .fetch   (tgt_fetch[i]),
            .clr_dlv (clr_wr && reg_wdata[DLV_LSB + i]),
            .clr_ovf (clr_wr && reg_wdata[OVF_LSB + i]),
            .msg_in  (msg),
            .busy    (busy[i]),
            .dlv     (dlv[i]),
            .ovf     (ovf[i]),
            .msg_out (tgt_data[i*MSG_W +: MSG_W]),
            .ev_acc  (ev_acc[i]),
            .ev_ovf  (ev_ovf[i]),
            .ev_dlv  (ev_dlv[i])
        );
    end

    mbx_irq u_irq (
        .clk, .rst_n, .mask,
        .any_acc (|ev_acc),
        .any_ovf (|ev_ovf),
        .any_dlv (|ev_dlv),
        .pend_clr,
        .pend
    );

    assign tgt_valid = busy;
    assign irq       = pend;

    // R3: one trigger touches at most one target
    p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev_acc | ev_ovf));
    // R10: pending bits rise only where a send was accepted
    p_rise_only_sent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy & ~$past(busy)) & ~$past(ev_acc)) == '0);
endmodule

// File: tb/mbx_outbound_test.sv
module mbx_outbound_test;
    import mbx_pkg::*;

    logic                   clk = 0;
    logic                   rst_n = 0;
    logic                   reg_wr = 0;
    logic [ADDR_W-1:0]      reg_addr = '0;
    logic [WORD_W-1:0]      reg_wdata = '0;
    logic [WORD_W-1:0]      reg_rdata;
    logic [N_TGT-1:0]       tgt_valid;
    logic [N_TGT*MSG_W-1:0] tgt_data;
    logic [N_TGT-1:0]       tgt_fetch = '0;
    logic                   irq;

    int n_chk = 0;
    int n_bad = 0;

    mbx_outbound uut (.*);

    always #2.5 clk = ~clk;

    initial begin
        #100000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [WORD_W-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic fetch(int i);
        @(negedge clk);
        tgt_fetch[i] = 1'b1;
        @(negedge clk);
        tgt_fetch = '0;
    endtask

    task automatic send(logic [2:0] t, logic [63:0] m);
        wr(OFS_LO, m[31:0]);
        wr(OFS_HI, m[63:32]);
        wr(OFS_TGT, {29'd0, t});
        wr(OFS_TRIG, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(OFS_STS, v);  check("R1 status", v, 0);
        rd(OFS_MASK, v); check("R1 mask", v, 7);
        rd(OFS_PEND, v); check("R1 pend", v, 0);
        check("R1 irq", irq, 0);
        check("R1 valid", tgt_valid, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(OFS_LO, 32'hA5A5_1234); wr(OFS_HI, 32'h0F0F_5678); wr(OFS_TGT, 32'hFFFF_FFF5);
        rd(OFS_LO, v);  check("R2 low", v, 32'hA5A5_1234);
        rd(OFS_HI, v);  check("R2 high", v, 32'h0F0F_5678);
        rd(OFS_TGT, v); check("R2 target", v, 5);
    endtask

    task automatic t_send_overflow();
        logic [31:0] v;
        send(3'd3, 64'h1111_2222_3333_4444);
        rd(OFS_STS, v); check("R3 busy", v, 32'h8);
        check("R3 valid", tgt_valid, 8'h08);
        check("R3 slot", tgt_data[3*64 +: 64], 64'h1111_2222_3333_4444);
        check("R8 masked irq", irq, 0);
        wr(OFS_TRIG, 32'h0);
        rd(OFS_STS, v); check("R3 trigger zero", v, 32'h8);
        send(3'd3, 64'hDEAD_BEEF_0000_0001);
        rd(OFS_STS, v); check("R5 overflow", v, 32'h808);
        check("R5 slot kept", tgt_data[3*64 +: 64], 64'h1111_2222_3333_4444);
        fetch(5);
        rd(OFS_STS, v); check("R6 idle fetch", v, 32'h808);
        fetch(3);
        rd(OFS_STS, v); check("R4 delivered", v, 32'h0008_0800);
        check("R4 valid", tgt_valid, 0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        send(3'd1, 64'h5);
        wr(OFS_CLR, 32'h0000_0800);
        rd(OFS_STS, v); check("R7 ovf only", v, 32'h0008_0002);
        wr(OFS_CLR, 32'h00FF_FFFF);
        rd(OFS_STS, v); check("R7 all flags, busy kept", v, 32'h0000_0002);
        send(3'd6, 64'h6);
        rd(OFS_STS, v); check("R10 independent", v, 32'h0000_0042);
        check("R10 slot1", tgt_data[1*64 +: 64], 64'h5);
        fetch(1); fetch(6);
        wr(OFS_CLR, 32'h00FF_FF00);
        rd(OFS_STS, v); check("R7 clean", v, 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(OFS_MASK, 32'h3);
        send(3'd0, 64'h10);
        check("R8 accept masked", irq, 0);
        fetch(0);
        check("R9 delivery irq", irq, 1);
        rd(OFS_PEND, v); check("R9 pend read", v, 1);
        wr(OFS_PEND, 32'h1);
        check("R9 cleared", irq, 0);
        wr(OFS_MASK, 32'h5);
        send(3'd0, 64'h11);
        check("R8 accept still masked", irq, 0);
        send(3'd0, 64'h12);
        check("R8 overflow irq", irq, 1);
        wr(OFS_PEND, 32'h1);
        wr(OFS_MASK, 32'h6);
        fetch(0);
        check("R8 delivery masked", irq, 0);
        send(3'd2, 64'h13);
        check("R8 accept irq", irq, 1);
        wr(OFS_PEND, 32'h1);
        wr(OFS_MASK, 32'h3);
        @(negedge clk);
        reg_wr = 1; reg_addr = OFS_PEND; reg_wdata = 32'h1; tgt_fetch[2] = 1'b1;
        @(negedge clk);
        reg_wr = 0; tgt_fetch = '0;
        check("R9 set wins over clear", irq, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regs();
        t_send_overflow();
        t_clear();
        t_irq();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule